// File: doc/BRIEF.md
# Self-Timed Program Sequencer for a Serial Nonvolatile Memory

This block is the internal controller of a small serial nonvolatile memory. It runs three programming operations once the serial front end has decoded an instruction: a single-word write, an erase-all that sets every word to all ones, and a write-all. The write-all first makes a full erase pass over the array and then fills every word with the supplied data. The memory array is modelled inside the block as a register file, and a combinational read port exposes it.

An operation is launched by the falling edge of the chip-select line. The decoded request, its operands and the permission inputs are sampled on that same clock edge. From then on the block times itself on its free-running clock and needs no further chip-select or serial activity. If the host raises chip select after holding it low long enough, the status outputs report busy or ready. A separate grant input carries the protection verdict for the target word. The serial shifter and the protect-address logic sit outside this block.

Top module: `prog_seq`

## Requirements
- R1: An operation is sampled only on a clock edge where `chipSel` is low and was high on the edge before. `pgmEn` must be high on that edge. Changing `pgmEn`, `opReq`, `addr` or `data` after that edge has no effect on the running operation.
- R2: `statusDrive` is high only while `chipSel` is high and the preceding low period lasted at least `CSL_MIN` clock edges. `statusBit` is 0 while an operation runs and 1 when the block is ready.
- R3: An accepted single-word write (`opReq` = 2'b01) keeps the block busy for exactly `WRITE_UNITS*TICK_PER_UNIT` cycles. At the end it stores `data` at `addr` and leaves all other words unchanged.
- R4: An accepted erase-all (`opReq` = 2'b10) keeps the block busy for exactly `ERAL_UNITS*TICK_PER_UNIT` cycles and leaves every word all ones.
- R5: An accepted write-all (`opReq` = 2'b11) first sets every word to all ones and only then begins the data pass. It stays busy through both passes, for exactly `WRAL_UNITS*TICK_PER_UNIT` cycles, and leaves every word equal to `data`.
- R6: Erase-all and write-all are accepted only when `wrEnable` and `protClear` are both high. A single-word write is accepted only when `wrEnable` and `addrGrant` are both high.
- R7: A rejected request, including `opReq` = 2'b00, leaves the array unchanged and `statusBit` stays 1.
- R8: A chip-select falling edge that arrives while an operation is running is ignored. The running operation keeps its length and its result.
- R9: `opDone` pulses high for exactly one cycle when each accepted operation finishes.
- R10: A single operation never holds the block busy longer than `ERAL_MAX_UNITS*TICK_PER_UNIT` cycles for an erase-all, or `WRAL_MAX_UNITS*TICK_PER_UNIT` cycles for the other operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipSel | input | 1 | Chip select; its falling edge launches an operation |
| opReq | input | 2 | Decoded request: 00 none, 01 word write, 10 erase-all, 11 write-all |
| addr | input | ADDR_W | Target word address |
| data | input | DATA_W | Data word to program |
| pgmEn | input | 1 | Program-enable level, required while the instruction loads |
| wrEnable | input | 1 | Write-enable state from the instruction decoder |
| protClear | input | 1 | High when the protect register is cleared |
| addrGrant | input | 1 | High when the target address is unprotected |
| rdAddr | input | ADDR_W | Array read address |
| rdData | output | DATA_W | Array word at rdAddr |
| statusBit | output | 1 | 0 while busy, 1 when ready |
| statusDrive | output | 1 | High when the status bit may drive the data line |
| opDone | output | 1 | One-cycle pulse at the end of an accepted operation |

## Verification
On every cycle, the embedded assertions check the following. Array writes happen only inside an operation. No capture occurs while busy. The data pass of write-all begins only after every word has been erased. `opDone` is a single pulse. `statusDrive` requires `chipSel` high. Busy rises only after a chip-select fall. No operation runs past its maximum length. Only the bench's scenarios can show that the stored values are correct, that the operation lengths are exact, and that a rejected or mid-operation request leaves the array untouched. The bench shows this through a write sweep over every address, reads of the array during the write-all erase pass, and the permission-denied cases.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  typedef enum logic [1:0] {
    OP_NONE      = 2'b00,
    OP_WORD      = 2'b01,
    OP_ERASE_ALL = 2'b10,
    OP_WRITE_ALL = 2'b11
  } opCode_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WORD,
    ST_ERASE,
    ST_FILL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch address and data of a new operation
    logic we;       // write one array word this cycle
    logic walk;     // address comes from the walking index, not the latch
    logic ones;     // write value is all ones, not the latched data
  } dpStrobe_t;

endpackage

// File: rtl/prog_seq_ctrl.sv
module prog_seq_ctrl
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int TICK_PER_UNIT  = 4,
  parameter int WRITE_UNITS    = 4,
  parameter int ERAL_UNITS     = 8,
  parameter int WRAL_UNITS     = 16,
  parameter int ERAL_MAX_UNITS = 15,
  parameter int WRAL_MAX_UNITS = 30,
  parameter int CSL_MIN        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic [1:0]        opReq,
  input  logic              pgmEn,
  input  logic              wrEnable,
  input  logic              protClear,
  input  logic              addrGrant,
  output dpStrobe_t         strb,
  output logic [ADDR_W-1:0] walkIdx,
  output logic              busy,
  output logic              opDone,
  output logic              statusDrive
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int WORD_TICKS = WRITE_UNITS * TICK_PER_UNIT;
  localparam int ERAL_TICKS = ERAL_UNITS * TICK_PER_UNIT;
  localparam int WRAL_TICKS = WRAL_UNITS * TICK_PER_UNIT;
  localparam int FILL_TICKS = WRAL_TICKS - ERAL_TICKS;
  localparam int ERAL_LIMIT = ERAL_MAX_UNITS * TICK_PER_UNIT;
  localparam int WRAL_LIMIT = WRAL_MAX_UNITS * TICK_PER_UNIT;
  localparam int TW         = $clog2(WRAL_TICKS + 1);
  localparam int IW         = ADDR_W + 1;
  localparam int LW         = $clog2(CSL_MIN + 1);
  localparam int BW         = $clog2(WRAL_LIMIT + 2);

  seqState_t       state;
  logic [TW-1:0]   timer;
  logic [IW-1:0]   wordIdx;
  logic            isWral;
  logic            csPrev;
  logic [LW-1:0]   lowCnt;
  logic            lowOk;
  logic            startEdge;
  logic            permit;
  logic            accept;
  logic            walking;
  logic            lastTick;

  assign startEdge = csPrev & ~chipSel;
  assign busy      = (state != ST_IDLE);
  assign lastTick  = (timer == '0);
  assign walking   = (state == ST_ERASE) || (state == ST_FILL);

  always_comb begin
    unique case (opCode_t'(opReq))
      OP_WORD:                    permit = addrGrant;
      OP_ERASE_ALL, OP_WRITE_ALL: permit = protClear;
      default:                    permit = 1'b0;
    endcase
  end

  assign accept = startEdge & ~busy & pgmEn & wrEnable & permit;

  always_comb begin
    strb.capture = accept;
    strb.walk    = walking;
    strb.ones    = (state == ST_ERASE);
    strb.we      = ((state == ST_WORD) && lastTick) ||
                   (walking && (wordIdx < IW'(DEPTH)));
  end
  assign walkIdx = wordIdx[ADDR_W-1:0];

  // sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      wordIdx <= '0;
      isWral  <= 1'b0;
      opDone  <= 1'b0;
    end else begin
      opDone <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            wordIdx <= '0;
            isWral  <= (opCode_t'(opReq) == OP_WRITE_ALL);
            if (opCode_t'(opReq) == OP_WORD) begin
              state <= ST_WORD;
              timer <= TW'(WORD_TICKS - 1);
            end else begin
              state <= ST_ERASE;
              timer <= TW'(ERAL_TICKS - 1);
            end
          end
        end
        ST_WORD: begin
          if (lastTick) begin
            state  <= ST_IDLE;
            opDone <= 1'b1;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_ERASE, ST_FILL: begin
          if (wordIdx < IW'(DEPTH)) wordIdx <= wordIdx + 1'b1;
          if (lastTick) begin
            if (state == ST_ERASE && isWral) begin
              state   <= ST_FILL;
              timer   <= TW'(FILL_TICKS - 1);
              wordIdx <= '0;
            end else begin
              state  <= ST_IDLE;
              opDone <= 1'b1;
            end
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // chip-select low-time qualification for status reporting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev <= 1'b0;
      lowCnt <= '0;
      lowOk  <= 1'b0;
    end else begin
      csPrev <= chipSel;
      if (!chipSel) begin
        lowOk <= 1'b0;
        if (lowCnt < LW'(CSL_MIN)) lowCnt <= lowCnt + 1'b1;
      end else begin
        lowCnt <= '0;
        if (!csPrev) lowOk <= (lowCnt >= LW'(CSL_MIN));
      end
    end
  end

  assign statusDrive = chipSel & lowOk;

  // ---------------- checker state and assertions ----------------
  logic [BW-1:0] busyCnt;
  logic [IW-1:0] eraseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt  <= '0;
      eraseCnt <= '0;
    end else begin
      busyCnt <= busy ? busyCnt + 1'b1 : '0;
      if (accept) eraseCnt <= '0;
      else if (strb.we && strb.ones && eraseCnt < IW'(DEPTH)) eraseCnt <= eraseCnt + 1'b1;
    end
  end

  // R10: bounded operation length
  a_r10_max_length: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < BW'((state == ST_ERASE && !isWral) ? ERAL_LIMIT : WRAL_LIMIT)));

  // R5: data pass starts only after the whole array was erased
  a_r5_erase_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL) |-> (eraseCnt == IW'(DEPTH)));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);

  // R1: busy only rises after a sampled chip-select fall
  a_r1_start_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(chipSel, 2) && !$past(chipSel)));

  // R2: status is driven only with chip select high
  a_r2_drive_high: assert property (@(posedge clk) disable iff (!rstN)
    statusDrive |-> chipSel);

endmodule

// File: rtl/prog_seq_dp.sv
module prog_seq_dp
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] walkIdx,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;
  logic [ADDR_W-1:0] wrIdx;
  logic [DATA_W-1:0] wrVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr <= '0;
      capData <= '0;
    end else if (strb.capture) begin
      capAddr <= addr;
      capData <= data;
    end
  end

  assign wrIdx = strb.walk ? walkIdx : capAddr;
  assign wrVal = strb.ones ? '1 : capData;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rstN)                                mem[i] <= '0;
        else if (strb.we && wrIdx == ADDR_W'(i)) mem[i] <= wrVal;
      end
    end
  endgenerate

  assign rdData = mem[rdAddr];

  // R7: the array is written only inside an accepted operation
  a_r7_write_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.we |-> busy);

  // R8: no new capture while an operation runs
  a_r8_capture_idle: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> !busy);

endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int DATA_W         = 8,
  parameter int TICK_PER_UNIT  = 4,
  parameter int WRITE_UNITS    = 4,
  parameter int ERAL_UNITS     = 8,
  parameter int WRAL_UNITS     = 16,
  parameter int ERAL_MAX_UNITS = 15,
  parameter int WRAL_MAX_UNITS = 30,
  parameter int CSL_MIN        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic [1:0]        opReq,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              pgmEn,
  input  logic              wrEnable,
  input  logic              protClear,
  input  logic              addrGrant,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              statusBit,
  output logic              statusDrive,
  output logic              opDone
);

  dpStrobe_t         strb;
  logic [ADDR_W-1:0] walkIdx;
  logic              busy;

  prog_seq_ctrl #(
    .ADDR_W(ADDR_W), .TICK_PER_UNIT(TICK_PER_UNIT), .WRITE_UNITS(WRITE_UNITS),
    .ERAL_UNITS(ERAL_UNITS), .WRAL_UNITS(WRAL_UNITS),
    .ERAL_MAX_UNITS(ERAL_MAX_UNITS), .WRAL_MAX_UNITS(WRAL_MAX_UNITS),
    .CSL_MIN(CSL_MIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .opReq(opReq), .pgmEn(pgmEn),
    .wrEnable(wrEnable), .protClear(protClear), .addrGrant(addrGrant),
    .strb(strb), .walkIdx(walkIdx), .busy(busy), .opDone(opDone),
    .statusDrive(statusDrive)
  );

  prog_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .walkIdx(walkIdx), .busy(busy),
    .addr(addr), .data(data), .rdAddr(rdAddr), .rdData(rdData)
  );

  assign statusBit = ~busy;

endmodule

// File: tb/prog_seq_bench.sv
`timescale 1ns/100ps
module prog_seq_bench;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int TPU = 4;
  localparam int T_WORD = 4 * TPU;
  localparam int T_ERAL = 8 * TPU;
  localparam int T_WRAL = 16 * TPU;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          chipSel = 1'b1;
  logic [1:0]    opReq = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          pgmEn = 1'b0, wrEnable = 1'b0, protClear = 1'b0, addrGrant = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic          statusBit, statusDrive, opDone;

  int nChk = 0;
  int nBad = 0;
  bit summaryDone = 0;
  logic [DW-1:0] expMem [DEPTH];

  always #10 clk = ~clk;

  prog_seq u_prog_seq (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .opReq(opReq), .addr(addr),
    .data(data), .pgmEn(pgmEn), .wrEnable(wrEnable), .protClear(protClear),
    .addrGrant(addrGrant), .rdAddr(rdAddr), .rdData(rdData),
    .statusBit(statusBit), .statusDrive(statusDrive), .opDone(opDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic compareAll(input string req);
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      rdAddr = AW'(i);
      #0.5;
      check(rdData == expMem[i], req, rdData, expMem[i]);
    end
  endtask

  // launch one request and count busy cycles; midErase checks the erase pass
  task automatic runOp(input logic [1:0] op, input int a, input int d,
                       input bit pe, input bit we, input bit pc, input bit gr,
                       input int expTicks, input bit midErase, input string req);
    int busyN = 0;
    int doneN = 0;
    @(negedge clk);
    opReq = op; addr = AW'(a); data = DW'(d);
    pgmEn = pe; wrEnable = we; protClear = pc; addrGrant = gr;
    chipSel = 1'b1;
    @(negedge clk);
    chipSel = 1'b0;
    for (int k = 1; k <= expTicks + 4; k++) begin
      @(negedge clk);
      if (!statusBit) busyN++;
      if (opDone) doneN++;
      if (k == 1) begin
        // R1: inputs after the launch edge are ignored
        pgmEn = 1'b0; opReq = 2'b00; addr = ~addr; data = ~data;
      end
      if (midErase && k >= 18 && k < 18 + DEPTH) begin
        rdAddr = AW'(k - 18);
        #0.5;
        check(rdData == '1, "R5 erase pass before data pass", rdData, 255);
      end
    end
    check(busyN == expTicks, req, busyN, expTicks);
    check(doneN == (expTicks > 0 ? 1 : 0), "R9 done pulse count", doneN, (expTicks > 0 ? 1 : 0));
    chipSel = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    nBad++;
    $display("FAIL watchdog actual=0 expected=1");
    if (!summaryDone) $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) expMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(statusBit == 1'b1, "R2 reset ready", statusBit, 1);
    check(statusDrive == 1'b0, "R2 reset drive", statusDrive, 0);
    check(opDone == 1'b0, "R9 reset done", opDone, 0);
    compareAll("R7 reset array");

    // R6/R7: rejected requests
    runOp(2'b01, 3, 8'h11, 1, 1, 1, 0, 0, 0, "R6 write denied by grant");
    runOp(2'b01, 3, 8'h11, 1, 0, 1, 1, 0, 0, "R6 write denied by wrEnable");
    runOp(2'b01, 3, 8'h11, 0, 1, 1, 1, 0, 0, "R1 write denied by pgmEn");
    runOp(2'b10, 0, 0,     1, 1, 0, 1, 0, 0, "R6 erase-all denied by protClear");
    runOp(2'b11, 0, 8'h22, 1, 0, 1, 1, 0, 0, "R6 write-all denied by wrEnable");
    runOp(2'b00, 2, 8'h33, 1, 1, 1, 1, 0, 0, "R7 no-op request");
    compareAll("R7 array after rejects");

    // R3: write sweep over every address
    for (int a = 0; a < DEPTH; a++) begin
      runOp(2'b01, a, (a * 37 + 11) & 8'hFF, 1, 1, 0, 1, T_WORD, 0, "R3 word write length");
      expMem[a] = DW'((a * 37 + 11) & 8'hFF);
    end
    compareAll("R3 array after write sweep");

    // R8 and R2: reselect during a word write
    begin
      int busyN = 0;
      @(negedge clk);
      opReq = 2'b01; addr = 4'd5; data = 8'hA5;
      pgmEn = 1; wrEnable = 1; protClear = 1; addrGrant = 1;
      chipSel = 1'b1;
      @(negedge clk);
      chipSel = 1'b0;
      for (int k = 1; k <= T_WORD + 4; k++) begin
        @(negedge clk);
        if (!statusBit) busyN++;
        if (k == 2) check(statusDrive == 1'b0, "R2 no drive while low", statusDrive, 0);
        if (k == 4) chipSel = 1'b1;
        if (k == 5) begin
          check(statusDrive == 1'b1, "R2 drive after long low", statusDrive, 1);
          check(statusBit == 1'b0, "R2 busy reported", statusBit, 0);
          opReq = 2'b11; data = 8'h3C; chipSel = 1'b0;
        end
      end
      check(busyN == T_WORD, "R8 ignored restart length", busyN, T_WORD);
      expMem[5] = 8'hA5;
      chipSel = 1'b1;
      compareAll("R8 array after ignored restart");
    end

    // R2: short and long low periods while idle
    @(negedge clk); opReq = 2'b00; chipSel = 1'b0;
    repeat (2) @(negedge clk);
    chipSel = 1'b1;
    @(negedge clk);
    check(statusDrive == 1'b0, "R2 short low gives no drive", statusDrive, 0);
    chipSel = 1'b0;
    repeat (3) @(negedge clk);
    chipSel = 1'b1;
    @(negedge clk);
    check(statusDrive == 1'b1, "R2 minimum low gives drive", statusDrive, 1);
    check(statusBit == 1'b1, "R2 ready reported", statusBit, 1);

    // R4: erase-all
    runOp(2'b10, 0, 0, 1, 1, 1, 0, T_ERAL, 0, "R4 erase-all length");
    for (int i = 0; i < DEPTH; i++) expMem[i] = '1;
    compareAll("R4 array all ones");

    // put data back so the erase pass is visible
    runOp(2'b01, 9, 8'h42, 1, 1, 0, 1, T_WORD, 0, "R3 word write length");
    expMem[9] = 8'h42;

    // R5: write-all with mid-operation reads
    runOp(2'b11, 0, 8'h5A, 1, 1, 1, 0, T_WRAL, 1, "R5 write-all length");
    for (int i = 0; i < DEPTH; i++) expMem[i] = 8'h5A;
    compareAll("R5 array all data");

    runOp(2'b11, 0, 8'h77, 1, 1, 0, 1, 0, 0, "R6 write-all denied by protClear");
    compareAll("R7 array after denied write-all");

    summaryDone = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule